// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns code-fetch and data-access requests from a small 8-bit processor core into pin-level bus cycles toward external memory. It runs on the oscillator clock and counts a 12-period machine cycle. It produces the address latch strobe (`ale`), the active-low program read strobe (`psen_n`) and the active-low data read and write strobes (`rd_n`, `wr_n`). It drives a shared bus that carries the low address byte and the data, with its own output enable, plus a separate high address byte.

Each machine cycle holds two 6-period slots. A code fetch takes one slot. A data read or write takes a whole machine cycle. In that cycle the second address strobe and both program read strobes are left out, and one long read or write strobe takes their place. The address latch strobe keeps its cadence even when no request is pending. The core holds a request until `req_ready` pulses. The byte read back is returned on `rsp_data` with a one-period `rsp_done` pulse.

Top module: `xmem_seq`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe`, `rsp_done` and `req_ready` are 0 and `rsp_data` is 0. Release is synchronized over two clock edges. The first `ale` high period starts at the third rising edge after `rst_n` goes high.
- R2: Number the periods of a machine cycle 0 to 11, with slot positions 0 to 5 in each half. `ale` is high at positions 0 and 1 of every slot, including idle slots. The only exception is the second half of a data cycle, where it stays low.
- R3: In a fetch slot `psen_n` is low at positions 3 to 5. The bus is driven with the low byte of the fetch address at positions 0 to 2 and is released at positions 3 to 5. `addr_hi` carries the upper address byte.
- R4: In a data read cycle `rd_n` is low in periods 5 to 10, `psen_n` stays high for all 12 periods, and the bus is driven only in periods 0 to 2, with the low address byte.
- R5: In a data write cycle `wr_n` is low in periods 5 to 10. The bus carries the low address byte in periods 0 to 2 and the write byte in periods 3 to 11. It therefore holds the data one period after `wr_n` rises.
- R6: `req_wide`=1 selects 16-bit data addressing, with `addr_hi` = `req_addr[15:8]`. `req_wide`=0 makes `addr_hi` follow the `port2` input for the whole data cycle. Fetches always use `req_addr[15:8]`.
- R7: `req_kind` encoding: 0 is fetch, 1 is data read, 2 is data write, 3 is reserved and is never accepted. `req_ready` is high, combinationally, only when `req_valid` is set in the last period of a slot that may start a request. A fetch may start after period 5, unless a data cycle is running, or after period 11. A data request may start only after period 11. An accepted request occupies the next slot. With no acceptance the next slot is idle.
- R8: After the last low period of `psen_n` (fetch) or `rd_n` (data read), `rsp_done` is high for exactly one period. `rsp_data` then holds the byte that was on `ad_in` in that last low period, and keeps it until the next capture.
- R9: An idle slot pulses `ale` but drives no strobe, does not drive the bus and raises no `rsp_done`.
- R10: `ad_oe` is never high while `psen_n` or `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request pending |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 reserved |
| req_wide | input | 1 | Data access uses the 16-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| port2 | input | 8 | Port register used as high address in 8-bit data mode |
| ad_in | input | 8 | Bus value read from the pads |
| req_ready | output | 1 | Request accepted at the coming edge |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address byte or write data |
| ad_oe | output | 1 | Bus output enable |
| addr_hi | output | 8 | High address byte |
| rsp_done | output | 1 | Read byte returned |
| rsp_data | output | 8 | Returned byte |

## Verification
A wrong period count or slot type shows up at the pins within one period. The `ale` cadence drifts, a program read strobe appears inside a data cycle, or the long strobe moves off periods 5 to 10. A wrong latched address or write byte shows up when the next strobe falls. The bench emulates an external latch and memory, so such a fault appears as a wrong returned byte one period after the read strobe rises, or as a wrong write captured when `wr_n` rises. An acceptance fault shows in the same period as a `req_ready` that does not match the slot rule.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int MC_LEN    = 12;
  localparam int SLOT_LEN  = 6;
  localparam int PH_W      = $clog2(MC_LEN);
  localparam int ALE_END   = 2;   // ale high at slot positions below this
  localparam int ADR_END   = 3;   // address on bus below this position
  localparam int XS_FIRST  = 5;   // long strobe first low period
  localparam int XS_LAST   = 10;  // long strobe last low period

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_DRD   = 2'd1,
    K_DWR   = 2'd2,
    K_RSV   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_DRD   = 2'd2,
    S_DWR   = 2'd3
  } slot_e;
endpackage

// File: rtl/xmem_rst_sync.sv
module xmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xmem_phase.sv
module xmem_phase
  import xmem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] hp,
  output logic            second
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;

  assign ph_en = 1'b1;

  always_comb begin
    if (ph_q == PH_W'(MC_LEN - 1)) ph_d = '0;
    else                           ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= PH_W'(MC_LEN - 1);
    else if (ph_en) ph_q <= ph_d;
  end

  assign ph     = ph_q;
  assign second = (ph_q >= PH_W'(SLOT_LEN));
  assign hp     = second ? (ph_q - PH_W'(SLOT_LEN)) : ph_q;
endmodule

// File: rtl/xmem_slot.sv
module xmem_slot
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_wide,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output slot_e           slot,
  output logic [AW-1:0]   addr_q,
  output logic [DW-1:0]   wd_q,
  output logic            wide_q
);
  slot_e         slot_q, slot_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wd_d;
  logic          wide_d;
  logic          at_end, at_mid, data_busy, fetch_ok, data_ok;
  logic          want_fetch, want_data, accept, boundary;

  assign at_end     = (ph == PH_W'(MC_LEN - 1));
  assign at_mid     = (ph == PH_W'(SLOT_LEN - 1));
  assign data_busy  = (slot_q == S_DRD) || (slot_q == S_DWR);
  assign boundary   = at_end || (at_mid && !data_busy);
  assign fetch_ok   = boundary;
  assign data_ok    = at_end;
  assign want_fetch = (kind_e'(req_kind) == K_FETCH);
  assign want_data  = (kind_e'(req_kind) == K_DRD) || (kind_e'(req_kind) == K_DWR);
  // rst_ni low holds ph at the cycle end, so gate acceptance with it
  assign accept     = rst_ni && req_valid &&
                      ((want_fetch && fetch_ok) || (want_data && data_ok));

  always_comb begin
    slot_d = slot_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    wide_d = wide_q;
    if (boundary) begin
      slot_d = S_IDLE;
      if (accept) begin
        addr_d = req_addr;
        wd_d   = req_wdata;
        wide_d = req_wide;
        case (kind_e'(req_kind))
          K_FETCH: slot_d = S_FETCH;
          K_DRD:   slot_d = S_DRD;
          K_DWR:   slot_d = S_DWR;
          default: slot_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= S_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      wide_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      if (accept) begin
        addr_q <= addr_d;
        wd_q   <= wd_d;
        wide_q <= wide_d;
      end
    end
  end

  assign slot      = slot_q;
  assign req_ready = accept;
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  slot_e           slot,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] hp,
  input  logic            second,
  input  logic [AW-1:0]   addr_q,
  input  logic [DW-1:0]   wd_q,
  input  logic            wide_q,
  input  logic [DW-1:0]   port2,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [DW-1:0]   addr_hi
);
  logic is_data, long_win;

  assign is_data  = (slot == S_DRD) || (slot == S_DWR);
  assign long_win = (ph >= PH_W'(XS_FIRST)) && (ph <= PH_W'(XS_LAST));

  always_comb begin
    ale    = (hp < PH_W'(ALE_END)) && !(is_data && second);
    psen_n = !((slot == S_FETCH) && (hp >= PH_W'(ADR_END)));
    rd_n   = !((slot == S_DRD) && long_win);
    wr_n   = !((slot == S_DWR) && long_win);
    case (slot)
      S_FETCH: ad_oe = (hp < PH_W'(ADR_END));
      S_DRD:   ad_oe = (ph < PH_W'(ADR_END));
      S_DWR:   ad_oe = 1'b1;
      default: ad_oe = 1'b0;
    endcase
    if ((slot == S_DWR) && (ph >= PH_W'(ADR_END))) ad_out = wd_q;
    else                                            ad_out = addr_q[DW-1:0];
    if (is_data && !wide_q) addr_hi = port2;
    else                    addr_hi = addr_q[AW-1:DW];
  end
endmodule

// File: rtl/xmem_rdcap.sv
module xmem_rdcap
  import xmem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  slot_e           slot,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] hp,
  input  logic [DW-1:0]   ad_in,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_data
);
  logic          cap_en;
  logic          done_q;
  logic [DW-1:0] data_q;

  assign cap_en = ((slot == S_FETCH) && (hp == PH_W'(SLOT_LEN - 1))) ||
                  ((slot == S_DRD)   && (ph == PH_W'(XS_LAST)));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= cap_en;
      if (cap_en) data_q <= ad_in;
    end
  end

  assign rsp_done = done_q;
  assign rsp_data = data_q;
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] port2,
  input  logic [DW-1:0] ad_in,
  output logic          req_ready,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] addr_hi,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data
);
  logic            rst_ni;
  logic [PH_W-1:0] ph, hp;
  logic            second;
  slot_e           slot;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic            wide_q;

  xmem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  xmem_phase u_phase (
    .clk(clk), .rst_ni(rst_ni), .ph(ph), .hp(hp), .second(second)
  );

  xmem_slot #(.DW(DW)) u_slot (
    .clk(clk), .rst_ni(rst_ni), .ph(ph),
    .req_valid(req_valid), .req_kind(req_kind), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .slot(slot), .addr_q(addr_q), .wd_q(wd_q), .wide_q(wide_q)
  );

  xmem_pins #(.DW(DW)) u_pins (
    .slot(slot), .ph(ph), .hp(hp), .second(second),
    .addr_q(addr_q), .wd_q(wd_q), .wide_q(wide_q), .port2(port2),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi)
  );

  xmem_rdcap #(.DW(DW)) u_cap (
    .clk(clk), .rst_ni(rst_ni), .slot(slot), .ph(ph), .hp(hp),
    .ad_in(ad_in), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic rsp_done
);
  // R10
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> $past(ale, 2));

  // R3
  psen_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));

  // R4
  rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!$past(ale, 3) && $past(ale, 4)));

  // R2
  long_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (psen_n && !ale && (rd_n || wr_n)));

  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  // R8
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($rose(psen_n) || $rose(rd_n)));

  // R7
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
endmodule

bind xmem_seq xmem_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .rsp_done(rsp_done)
);

// File: tb/tb_xmem_seq.sv
`timescale 1ns/1ps
module tb_xmem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic [7:0]  port2 = 8'h00;
  logic [7:0]  ad_in;
  logic        req_ready, ale, psen_n, rd_n, wr_n, ad_oe, rsp_done;
  logic [7:0]  ad_out, addr_hi, rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  xmem_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .port2(port2), .ad_in(ad_in), .req_ready(req_ready), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .addr_hi(addr_hi), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // external address latch and memory
  logic [7:0] lat_lo = 8'h00;
  always @(negedge ale) lat_lo = ad_out;
  assign ad_in = mem({addr_hi, lat_lo});

  task automatic chk(input string r, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", r, nm, act, exp, cyc);
    end
  endtask

  // reference model: 0 idle, 1 fetch, 2 data read, 3 data write
  int          mph = 11, mslot = 0, rel = 0;
  logic [15:0] maddr = 0;
  logic [7:0]  mwd = 0, mrdata = 0;
  bit          mwide = 0, mdone = 0;
  logic [23:0] wr_q[$];

  function automatic bit exp_ready();
    bit bnd;
    if (rel < 2 || !req_valid) return 0;
    bnd = (mph == 11) || (mph == 5 && mslot < 2);
    if (req_kind == 2'd0) return bnd;
    if (req_kind == 2'd1 || req_kind == 2'd2) return mph == 11;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit acc, cap;
    logic [15:0] ra;
    cyc++;
    acc = exp_ready();
    cap = (mslot == 1 && mph % 6 == 5) || (mslot == 2 && mph == 10);
    ra  = (mslot == 2 && !mwide) ? {port2, maddr[7:0]} : maddr;
    if (!rst_n || rel < 2) begin
      mph = 11; mslot = 0; maddr = 0; mwd = 0; mwide = 0; mdone = 0; mrdata = 0;
    end else begin
      mdone = cap;
      if (cap) mrdata = mem(ra);
      if (mph == 11 || (mph == 5 && mslot < 2)) begin
        mslot = acc ? int'(req_kind) + 1 : 0;
        if (acc) begin
          maddr = req_addr; mwd = req_wdata; mwide = req_wide;
          if (req_kind == 2'd2)
            wr_q.push_back({req_wide ? req_addr[15:8] : port2, req_addr[7:0], req_wdata});
        end
      end
      mph = (mph + 1) % 12;
    end
    if (!rst_n) rel = 0;
    else if (rel < 2) rel++;
  end

  // writes seen by external memory, checked when wr_n rises
  always @(posedge wr_n) begin
    logic [23:0] e;
    if (rst_n) begin
      if (wr_q.size() == 0) chk("R5", "unexpected write", 1, 0);
      else begin
        e = wr_q.pop_front();
        chk("R5", "write addr/data", int'({addr_hi, lat_lo, ad_out}), int'(e));
        chk("R6", "write high address", int'(addr_hi), int'(e[23:16]));
      end
    end
  end

  always @(negedge clk) begin
    int hp;
    bit isd, eoe;
    string rs;
    hp  = mph % 6;
    isd = mslot >= 2;
    rs  = (rel < 2) ? "R1" : "R2";
    chk(rs, "ale", int'(ale), int'(hp < 2 && !(isd && mph >= 6)));
    chk((rel < 2) ? "R1" : "R3", "psen_n", int'(psen_n), int'(!(mslot == 1 && hp >= 3)));
    chk((rel < 2) ? "R1" : "R4", "rd_n", int'(rd_n), int'(!(mslot == 2 && mph >= 5 && mph <= 10)));
    chk((rel < 2) ? "R1" : "R5", "wr_n", int'(wr_n), int'(!(mslot == 3 && mph >= 5 && mph <= 10)));
    if (mslot == 3)      eoe = 1;
    else if (mslot == 1) eoe = hp < 3;
    else if (mslot == 2) eoe = mph < 3;
    else                 eoe = 0;
    chk((mslot == 0) ? "R9" : "R3", "ad_oe", int'(ad_oe), int'(eoe));
    if (eoe)
      chk((mslot == 3) ? "R5" : "R3", "ad_out", int'(ad_out),
          int'((mslot == 3 && mph >= 3) ? mwd : maddr[7:0]));
    if (mslot != 0)
      chk("R6", "addr_hi", int'(addr_hi), int'((isd && !mwide) ? port2 : maddr[15:8]));
    chk((rel < 2) ? "R1" : "R8", "rsp_done", int'(rsp_done), int'(mdone));
    if (mdone || rel < 2) chk("R8", "rsp_data", int'(rsp_data), int'(mrdata));
    chk("R7", "req_ready", int'(req_ready), int'(exp_ready()));
  end

  task automatic issue(input logic [1:0] k, input bit w, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1; req_kind = k; req_wide = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk("R1", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] lf;
    // R1 reset state, also with a request pending
    req_valid = 1; req_kind = 2'd0;
    repeat (4) @(posedge clk);
    #2; req_valid = 0;
    @(negedge clk); rst_n = 1;
    idle(30);                                   // R9 idle cadence
    for (int i = 0; i < 6; i++) issue(2'd0, 1'b0, 16'h1200 + 16'(i * 7), 8'h00); // R3
    port2 = 8'hA5;
    issue(2'd1, 1'b1, 16'h1234, 8'h00);         // R4 R6 wide read
    issue(2'd1, 1'b0, 16'h0077, 8'h00);         // R6 narrow read
    issue(2'd2, 1'b1, 16'hBEEF, 8'h3C);         // R5 wide write
    issue(2'd2, 1'b0, 16'h00C3, 8'hE1);         // R5 R6 narrow write
    idle(7);
    issue(2'd0, 1'b0, 16'h4000, 8'h00);         // R7 fetch then data waits for cycle end
    issue(2'd1, 1'b1, 16'h4321, 8'h00);
    req_valid = 1; req_kind = 2'd3;             // R7 reserved kind never accepted
    idle(30);
    req_valid = 0;
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) idle(int'(lf[5:3]));
      issue((lf[9:8] == 2'd3) ? 2'd0 : lf[9:8], lf[10], lf ^ 16'h3C5A, lf[15:8]);
    end
    idle(24);
    chk("R5", "pending writes", wr_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule